// File: doc/BRIEF.md
# Card Bus Clock Generator

The block derives a card bus clock from the module clock through two cascaded counters. A prescaler stage yields one tick every P module cycles. P is 1 when the prescaler field is zero and twice the field otherwise. A divider stage then counts D+1 of those ticks per output period. Software picks both values and writes them as a single rate word. The output is a registered signal in the module clock domain. Each period begins with its high phase and ends with its low phase, so the last cycle of a period is always low.

A control word starts or stops the card clock. Either request is carried out only at a low point of the waveform. A stop lets the current period finish its low phase, and a start from the stopped state begins a fresh period at once. The control word also carries a reset bit. A tracker follows the multi-write soft-reset ritual and holds a reset line to neighbouring logic for as long as the ritual is in progress. A running flag shows whether the card clock is live.

The run control has three states. RUN_OFF moves to RUN_ON on a start request. RUN_ON moves to RUN_OFF on a stop request that falls on a period boundary, and to RUN_DRAIN on a stop request at any other time. RUN_DRAIN returns to RUN_ON on a start request and moves to RUN_OFF at the next period boundary.

The reset tracker also has three states. From any state, a reset-only write moves it to SEQ_ARMED. SEQ_ARMED moves to SEQ_COUNT on a reset-with-start write and to SEQ_IDLE on any other write. SEQ_COUNT counts start-only writes and returns to SEQ_IDLE after the eighth. Any other write in SEQ_COUNT also sends it back to SEQ_IDLE.

Top module: `cardclk_gen`

## Requirements
- R1: The rate word carries the divider field in bits [3:0] and the prescaler field p in bits [15:4]. A divider field of 0 acts as 1, giving D. The period is (D+1) module cycles when p is 0, and (D+1)*2*p module cycles otherwise.
- R2: Each period opens with a high phase of ((D+1)>>1) prescaled ticks, where a tick is 1 cycle if p is 0 and 2*p cycles otherwise. The rest of the period is low.
- R3: In the control word, bit 1 requests start and bit 0 requests stop, and stop wins when both are set. A start from the stopped state drives the clock high in the first cycle after the write edge.
- R4: A stop lets the running period complete through its low phase and then holds the clock low. A start that arrives before that boundary cancels the pending stop, and the clock continues without a break.
- R5: The running flag is high from the first cycle after a start up to and including the last cycle of a draining period, and low in every cycle where the clock is held stopped.
- R6: A rate write while running takes effect at the next period boundary. A write sampled in the last cycle of a period governs the very next period.
- R7: Bit 3 of the control word is the reset bit. A reset-only write (bit 3 set, bits 1 and 0 clear) raises the neighbour reset line on the next cycle. The line stays high through one reset-with-start write (bits 3 and 1) and seven start-only writes (bit 1 alone), and falls after the eighth start-only write. Any write that breaks the pattern drops the line on the next cycle, except a reset-only write, which re-arms it. Bit 2 is ignored.
- R8: A reset-only write leaves the card clock and the running flag unchanged. A reset-with-start write starts the clock like a plain start.
- R9: After reset, the card clock, the running flag and the neighbour reset line are all low, and the rate word is p=0 with divider 1.
- R10: The fastest setting (p=0, divider 1) gives one high and one low cycle. The slowest legal setting (p=0x800, divider 15) gives 32768 high and 32768 low cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock, the divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_we | input | 1 | Write strobe for the rate word |
| rate_wdata | input | 16 | Rate word: prescaler [15:4], divider [3:0] |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control word: stop [0], start [1], reset [3] |
| card_clk | output | 1 | Divided card bus clock |
| clk_running | output | 1 | High while the card clock is live |
| sib_reset | output | 1 | Reset line to neighbouring logic during the soft-reset ritual |

## Verification
Two things can happen in one cycle: a rate write and the period boundary that loads a new rate. The bench counts cycles from a period start and writes the new rate in exactly the last low cycle. It then requires the next period's high and low lengths to match the new rate rather than the old one. A stop and a start can also arrive together, either in one control write or as a start that lands while a stop is still draining. The bench judges these by whether the running flag falls at the next boundary or stays high with a fresh high phase.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    // Control word bit positions (software-visible)
    localparam int CTL_W     = 4;
    localparam int CTL_STOP  = 0;
    localparam int CTL_START = 1;
    localparam int CTL_RESET = 3;

    typedef enum logic [1:0] {
        RUN_OFF   = 2'd0,
        RUN_ON    = 2'd1,
        RUN_DRAIN = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_COUNT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic any_wr;
        logic stop;
        logic start;
        logic rst_only;
        logic rst_start;
        logic start_only;
    } ctl_req_t;

    // Classify one control write; stop takes priority over start.
    function automatic ctl_req_t decode_ctl(input logic we, input logic [CTL_W-1:0] w);
        ctl_req_t r;
        r.any_wr     = we;
        r.stop       = we && w[CTL_STOP];
        r.start      = we && w[CTL_START] && !w[CTL_STOP];
        r.rst_only   = we && w[CTL_RESET] && !w[CTL_START] && !w[CTL_STOP];
        r.rst_start  = we && w[CTL_RESET] && w[CTL_START] && !w[CTL_STOP];
        r.start_only = we && !w[CTL_RESET] && w[CTL_START] && !w[CTL_STOP];
        return r;
    endfunction

endpackage

// File: rtl/ckg_prescaler.sv
module ckg_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic [PRE_W-1:0] pre_fld,
    output logic             tick
);
    localparam int CNT_W = PRE_W + 1;

    logic [CNT_W-1:0] pcnt;
    logic [CNT_W-1:0] plast;

    // Tick length is 1 cycle for a zero field, else twice the field.
    always_comb begin
        if (pre_fld == '0) plast = '0;
        else               plast = {pre_fld, 1'b0} - 1'b1;
    end

    assign tick = (pcnt == plast);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt <= '0;
        else if (clr)      pcnt <= '0;
        else if (adv)      pcnt <= tick ? '0 : pcnt + 1'b1;
    end

    AST_PCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= plast); // R2

endmodule

// File: rtl/ckg_divider.sv
module ckg_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clr,
    input  logic [DIV_W-1:0] div_fld,
    output logic             last,
    output logic             hi_nxt
);
    logic [DIV_W-1:0] dcnt, dcnt_n, dlast;
    logic [DIV_W:0]   hi_ticks;

    // A zero divider behaves as one.
    always_comb begin
        dlast    = (div_fld == '0) ? DIV_W'(1) : div_fld;
        hi_ticks = ({1'b0, dlast} + 1'b1) >> 1;
    end

    assign last = (dcnt == dlast);

    always_comb begin
        if (clr)        dcnt_n = '0;
        else if (step)  dcnt_n = last ? '0 : dcnt + 1'b1;
        else            dcnt_n = dcnt;
    end

    // High phase covers the first half (rounded down) of the ticks.
    assign hi_nxt = ({1'b0, dcnt_n} < hi_ticks);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcnt <= '0;
        else        dcnt <= dcnt_n;
    end

    AST_DCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        dcnt <= dlast); // R1

endmodule

// File: rtl/ckg_rstseq.sv
module ckg_rstseq
    import ckg_pkg::*;
#(
    parameter int STARTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_wr,
    input  logic rst_only,
    input  logic rst_start,
    input  logic start_only,
    output logic sib_rst
);
    localparam int CW = (STARTS > 1) ? $clog2(STARTS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STARTS - 1);

    seq_state_e      sq, sq_n;
    logic [CW-1:0]   cnt, cnt_n;
    logic            sib_q;

    always_comb begin
        sq_n  = sq;
        cnt_n = cnt;
        if (any_wr) begin
            if (rst_only) begin
                sq_n  = SEQ_ARMED;
                cnt_n = '0;
            end else begin
                unique case (sq)
                    SEQ_IDLE: begin
                        sq_n = SEQ_IDLE;
                    end
                    SEQ_ARMED: begin
                        cnt_n = '0;
                        sq_n  = rst_start ? SEQ_COUNT : SEQ_IDLE;
                    end
                    SEQ_COUNT: begin
                        if (start_only && cnt != LAST) begin
                            cnt_n = cnt + 1'b1;
                        end else begin
                            sq_n  = SEQ_IDLE;
                            cnt_n = '0;
                        end
                    end
                    default: begin
                        sq_n  = SEQ_IDLE;
                        cnt_n = '0;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            sq  <= sq_n;
            cnt <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sib_q <= 1'b0;
        else        sib_q <= (sq_n != SEQ_IDLE);
    end

    assign sib_rst = sib_q;

    AST_SEQ_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sq != SEQ_COUNT) |-> (cnt == '0)); // R7
    AST_SEQ_DROP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sib_rst) |-> $past(any_wr)); // R7
    AST_SEQ_LINE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sib_rst == (sq != SEQ_IDLE)); // R7

endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
    import ckg_pkg::*;
#(
    parameter int              PRE_W      = 12,
    parameter int              DIV_W      = 4,
    parameter int              SEQ_STARTS = 8,
    parameter logic [11:0]     RST_PRE    = 12'd0,
    parameter logic [3:0]      RST_DIV    = 4'd1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rate_we,
    input  logic [PRE_W+DIV_W-1:0] rate_wdata,
    input  logic                   ctrl_we,
    input  logic [CTL_W-1:0]       ctrl_wdata,
    output logic                   card_clk,
    output logic                   clk_running,
    output logic                   sib_reset
);
    localparam int RATE_W = PRE_W + DIV_W;

    ctl_req_t          req;
    logic [PRE_W-1:0]  pend_pre, act_pre, nxt_pre;
    logic [DIV_W-1:0]  pend_div, act_div, nxt_div;
    run_state_e        st, st_n;
    logic              adv, clr, tick, last, bnd, hi_nxt;
    logic              card_q;

    always_comb req = decode_ctl(ctrl_we, ctrl_wdata);

    // Rate shadow: a write in the same cycle bypasses the shadow copy.
    always_comb begin
        nxt_pre = rate_we ? rate_wdata[RATE_W-1:DIV_W] : pend_pre;
        nxt_div = rate_we ? rate_wdata[DIV_W-1:0]      : pend_div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_pre <= PRE_W'(RST_PRE);
            pend_div <= DIV_W'(RST_DIV);
        end else begin
            pend_pre <= nxt_pre;
            pend_div <= nxt_div;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_pre <= PRE_W'(RST_PRE);
            act_div <= DIV_W'(RST_DIV);
        end else if (st == RUN_OFF || bnd) begin
            act_pre <= nxt_pre;
            act_div <= nxt_div;
        end
    end

    assign adv = (st != RUN_OFF);
    assign bnd = adv && tick && last;
    assign clr = (st_n == RUN_OFF);

    ckg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (adv),
        .clr     (clr),
        .pre_fld (act_pre),
        .tick    (tick)
    );

    ckg_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (adv && tick),
        .clr     (clr),
        .div_fld (act_div),
        .last    (last),
        .hi_nxt  (hi_nxt)
    );

    ckg_rstseq #(.STARTS(SEQ_STARTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_wr     (req.any_wr),
        .rst_only   (req.rst_only),
        .rst_start  (req.rst_start),
        .start_only (req.start_only),
        .sib_rst    (sib_reset)
    );

    // Run-state transitions
    always_comb begin
        st_n = st;
        unique case (st)
            RUN_OFF: begin
                if (req.start) st_n = RUN_ON;
            end
            RUN_ON: begin
                if (req.stop) st_n = bnd ? RUN_OFF : RUN_DRAIN;
            end
            RUN_DRAIN: begin
                if (req.start)  st_n = RUN_ON;
                else if (bnd)   st_n = RUN_OFF;
            end
            default: st_n = RUN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RUN_OFF;
        else        st <= st_n;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) card_q <= 1'b0;
        else        card_q <= (st_n != RUN_OFF) && hi_nxt;
    end

    assign card_clk    = card_q;
    assign clk_running = (st != RUN_OFF);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RUN_OFF) |-> !card_clk); // R4
    AST_STOP_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_running) |-> !$past(card_clk)); // R4
    AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> card_clk); // R3
    AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RUN_OFF && !bnd) |=> ($stable(act_pre) && $stable(act_div))); // R6
    AST_DRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RUN_DRAIN && bnd && !req.start) |=> !clk_running); // R5

endmodule

// File: tb/cardclk_gen_tb_top.sv
module cardclk_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 70000;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rate_we = 1'b0;
    logic [15:0] rate_wdata = '0;
    logic        ctrl_we = 1'b0;
    logic [3:0]  ctrl_wdata = '0;
    logic        card_clk, clk_running, sib_reset;
    int          checks = 0;
    int          failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cardclk_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rate_we     (rate_we),
        .rate_wdata  (rate_wdata),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .card_clk    (card_clk),
        .clk_running (clk_running),
        .sib_reset   (sib_reset)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // All drive tasks are entered at a falling edge and return at the next one.
    task automatic rate_wr(input int p, input int d);
        rate_we    = 1'b1;
        rate_wdata = {p[11:0], d[3:0]};
        @(negedge clk);
        rate_we    = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [3:0] v);
        ctrl_we    = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_we    = 1'b0;
        ctrl_wdata = '0;
    endtask

    task automatic meas(output int h, output int l);
        h = 0;
        while (card_clk === 1'b1 && h < LIM) begin h++; @(negedge clk); end
        l = 0;
        while (card_clk === 1'b0 && clk_running === 1'b1 && l < LIM) begin l++; @(negedge clk); end
    endtask

    task automatic wait_off(output int n);
        n = 0;
        while (clk_running === 1'b1 && n < LIM) begin n++; @(negedge clk); end
    endtask

    function automatic int tick_len(input int p);
        return (p == 0) ? 1 : 2 * p;
    endfunction

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        finish_run();
    end

    initial begin
        int h, l, n, hi, lo, dd, pp;
        repeat (3) @(negedge clk);
        chk_eq("R9 card_clk in reset", int'(card_clk), 0);
        chk_eq("R9 running in reset", int'(clk_running), 0);
        chk_eq("R9 sib_reset in reset", int'(sib_reset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R9 card_clk after reset", int'(card_clk), 0);

        // Soft-reset ritual, default rate p=0 d=1
        ctrl_wr(4'b1000);
        chk_eq("R7 line up after reset-only", int'(sib_reset), 1);
        chk_eq("R8 reset-only keeps clock stopped", int'(clk_running), 0);
        chk_eq("R8 reset-only keeps card low", int'(card_clk), 0);
        ctrl_wr(4'b1010);
        chk_eq("R7 line held after reset+start", int'(sib_reset), 1);
        chk_eq("R8 reset+start starts clock", int'(clk_running), 1);
        chk_eq("R3 first cycle high", int'(card_clk), 1);
        for (int i = 0; i < 7; i++) begin
            ctrl_wr(4'b0010);
            chk_eq("R7 line held during start writes", int'(sib_reset), 1);
        end
        ctrl_wr(4'b0010);
        chk_eq("R7 line falls after eighth start", int'(sib_reset), 0);
        ctrl_wr(4'b1000);
        chk_eq("R7 re-armed", int'(sib_reset), 1);
        chk_eq("R8 reset-only while running", int'(clk_running), 1);
        ctrl_wr(4'b0010);
        chk_eq("R7 broken pattern drops line", int'(sib_reset), 0);
        ctrl_wr(4'b1000);
        ctrl_wr(4'b0000);
        chk_eq("R7 empty write drops line", int'(sib_reset), 0);
        ctrl_wr(4'b0001);
        wait_off(n);
        chk_eq("R5 stop reaches off", int'(clk_running), 0);

        // Sweep: divider 0..15, prescaler 0,1,2,4
        for (int pi = 0; pi < 4; pi++) begin
            for (int d = 0; d < 16; d++) begin
                pp = (pi == 0) ? 0 : (1 << (pi - 1));
                dd = eff_div(d);
                hi = ((dd + 1) / 2) * tick_len(pp);
                lo = (dd + 1) * tick_len(pp) - hi;
                rate_wr(pp, d);
                ctrl_wr(4'b0010);
                meas(h, l);
                chk_eq($sformatf("R1 R2 high p=%0d d=%0d", pp, d), h, hi);
                chk_eq($sformatf("R1 R2 low p=%0d d=%0d", pp, d), l, lo);
                meas(h, l);
                chk_eq($sformatf("R1 second period p=%0d d=%0d", pp, d), h + l, hi + lo);
                ctrl_wr(4'b0001);
                wait_off(n);
                chk_eq("R4 held low after stop", int'(card_clk), 0);
                if (pp == 0 && d == 1) begin
                    chk_eq("R10 fastest high", hi, 1);
                    chk_eq("R10 fastest low", lo, 1);
                end
            end
        end

        // R6: mid-period write waits for boundary
        rate_wr(0, 1);
        ctrl_wr(4'b0010);
        rate_wr(0, 3);
        chk_eq("R6 old period finishes low", int'(card_clk), 0);
        @(negedge clk);
        meas(h, l);
        chk_eq("R6 new rate high", h, 2);
        chk_eq("R6 new rate low", l, 2);
        // R6: write in the last cycle of a period
        repeat (3) @(negedge clk);
        chk_eq("R6 last cycle is low", int'(card_clk), 0);
        rate_wr(0, 5);
        meas(h, l);
        chk_eq("R6 boundary write high", h, 3);
        chk_eq("R6 boundary write low", l, 3);
        ctrl_wr(4'b0001);
        wait_off(n);

        // R4: start cancels a pending stop (p=0 d=3, 2 high 2 low)
        rate_wr(0, 3);
        ctrl_wr(4'b0010);
        ctrl_wr(4'b0001);
        ctrl_wr(4'b0010);
        repeat (2) @(negedge clk);
        chk_eq("R4 cancelled stop keeps running", int'(clk_running), 1);
        chk_eq("R4 cancelled stop new high phase", int'(card_clk), 1);
        // R3: stop and start together -> stop wins
        ctrl_wr(4'b0011);
        wait_off(n);
        chk_eq("R3 stop wins over start", int'(clk_running), 0);
        chk_eq("R3 stop wins, within period", int'(n <= 4), 1);

        // R4/R5: exact drain (p=1 d=3: 4 high, 4 low)
        rate_wr(1, 3);
        ctrl_wr(4'b0010);
        chk_eq("R5 running after start", int'(clk_running), 1);
        ctrl_wr(4'b0001);
        meas(h, l);
        chk_eq("R4 drain rest of high", h, 3);
        chk_eq("R5 drain full low phase", l, 4);
        chk_eq("R5 off right after low phase", int'(clk_running), 0);

        // R10: slowest setting
        rate_wr(12'h800, 15);
        ctrl_wr(4'b0010);
        ctrl_wr(4'b0001);
        meas(h, l);
        chk_eq("R10 slowest high", h + 1, 32768);
        chk_eq("R10 slowest low", l, 32768);
        chk_eq("R10 slowest stops", int'(clk_running), 0);

        finish_run();
    end

endmodule